// File: doc/BRIEF.md
# Programmable-Length Serial CRC Engine

This block adds and verifies a cyclic redundancy check on the messages of a two-wire sensor bus. It works one bit at a time. A start strobe loads the CRC register with a seed and latches the polynomial, the CRC length (0 to 8 bits) and the direction for the frame. Each data bit marked valid then goes through the CRC register, most significant bit first. An end-of-data strobe closes the data phase.

In generate direction, the block then presents the finished CRC on its serial output, MSB first. It advances one bit for each bit strobe until the programmed number of bits has gone out. In check direction, it compares the trailing CRC bits that arrive on the serial input against its own register. It then pulses a done flag together with a pass or fail result.

A length of zero disables protection: no bits are appended and every check passes. The reset-default configuration of the surrounding channel is polynomial 0x11 (x^4 + 1), seed 0x0A and a 4-bit CRC over 16-bit messages. Framing and line coding belong to neighbouring blocks.

Top module: `crc_engine`

## Requirements
- R1: After reset, `crc_out_vld`, `crc_out`, `chk_done` and `chk_ok` are all 0.
- R2: On `sof`, the CRC register takes `cfg_seed`, and `cfg_poly`, `cfg_len` and `mode_chk` are captured for the frame. Changes to these inputs after the `sof` cycle have no effect on that frame.
- R3: Each data bit with `bit_vld` high updates the register, MSB first. The feedback f is the register bit at position len-1 XOR the data bit. The register shifts left by one, is masked to len bits, and is XORed with `cfg_poly[len-1:0]` when f is 1. The x^len term is implicit.
- R4: In generate mode (`mode_chk`=0), `crc_out_vld` is high from the cycle after `eod` for exactly len bit strobes. `crc_out` shows the CRC MSB first and advances on each `bit_vld`.
- R5: With len 0, generate mode emits no CRC bit, and check mode pulses `chk_done` with `chk_ok`=1 in the cycle after `eod`.
- R6: In check mode (`mode_chk`=1), the len bits received after `eod` are compared MSB first with the computed CRC. `chk_done` is high for one cycle, in the cycle after the last CRC bit. `chk_ok` is 1 in that cycle only if every bit matched.
- R7: With polynomial 0x11, seed 0x0A and len 4 on a 16-bit message, any error burst of 4 bits or fewer across the 20-bit codeword makes the check fail.
- R8: A `cfg_len` above 8 behaves exactly as 8.
- R9: A `sof` in any state aborts the current frame and starts a new one.
- R10: `bit_in` is ignored in cycles where `bit_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_chk | input | 1 | 0 = generate, 1 = check; captured on sof |
| cfg_poly | input | 8 | Feedback taps below the implicit top term |
| cfg_seed | input | 8 | Initial register value |
| cfg_len | input | 4 | CRC length in bits, 0 to 8 (larger values clamp) |
| sof | input | 1 | Start-of-frame strobe |
| eod | input | 1 | End-of-data strobe |
| bit_vld | input | 1 | Bit strobe: qualifies bit_in and paces CRC bits |
| bit_in | input | 1 | Serial data or received CRC bit |
| crc_out | output | 1 | Current CRC bit in generate mode |
| crc_out_vld | output | 1 | CRC bits are being presented |
| chk_done | output | 1 | One-cycle pulse with the check result |
| chk_ok | output | 1 | Check passed (meaningful with chk_done) |

## Verification
The first CRC bit sits on `crc_out` one cycle after the `eod` edge. Each later bit appears one cycle after the edge that samples a `bit_vld`. `chk_done` rises in the cycle right after the edge that takes the last CRC bit, or right after `eod` when the length is zero, and drops one cycle later. The bench drives and samples one time unit after each rising edge. It therefore reads each result in exactly the cycle the requirements give, and reads `chk_done` again one cycle later to confirm the pulse has ended. Expected CRC values come from a bit-level model of R3 inside the bench, which clamps the length as R8 states.

// File: rtl/crc_pkg.sv
package crc_pkg;

   // Frame sequencing states
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_TX   = 2'd2,
      ST_RX   = 2'd3
   } crc_state_e;

   // Register operations requested by the sequencer
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_DATA  = 2'd2,
      OP_SHIFT = 2'd3
   } crc_op_e;

endpackage

// File: rtl/crc_len_decode.sv
// Turns a clamped length into a bit mask and a one-hot MSB selector.
module crc_len_decode #(
   parameter int MAX_W = 8,
   parameter int LEN_W = $clog2(MAX_W + 1)
) (
   input  logic [LEN_W-1:0] len,
   output logic [MAX_W-1:0] mask,
   output logic [MAX_W-1:0] top
);

   for (genvar i = 0; i < MAX_W; i++) begin : g_bit
      assign mask[i] = (len > LEN_W'(i));
      assign top[i]  = (len == LEN_W'(i + 1));
   end

endmodule

// File: rtl/crc_shift_reg.sv
// CRC state register with seed load, data update and plain shift-out.
module crc_shift_reg
   import crc_pkg::*;
#(
   parameter int MAX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  crc_op_e          op,
   input  logic [MAX_W-1:0] seed,
   input  logic [MAX_W-1:0] taps,
   input  logic [MAX_W-1:0] mask,
   input  logic [MAX_W-1:0] top,
   input  logic             din,
   output logic             msb
);

   logic [MAX_W-1:0] r_q;
   logic [MAX_W-1:0] r_d;
   logic [MAX_W-1:0] shifted;
   logic             fb;

   always_comb begin
      msb     = |(r_q & top);
      fb      = msb ^ din;
      shifted = (r_q << 1) & mask;
      unique case (op)
         OP_LOAD:  r_d = seed;
         OP_DATA:  r_d = shifted ^ (fb ? taps : '0);
         OP_SHIFT: r_d = shifted;
         default:  r_d = r_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else        r_q <= r_d;
   end

endmodule

// File: rtl/crc_ctrl.sv
// Frame sequencer: data phase, CRC emission or comparison, result pulse.
module crc_ctrl
   import crc_pkg::*;
#(
   parameter int MAX_W = 8,
   parameter int LEN_W = $clog2(MAX_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof,
   input  logic             eod,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             msb,
   input  logic             chk_mode,
   input  logic [LEN_W-1:0] len,
   output crc_op_e          op,
   output logic             out_vld,
   output logic             done,
   output logic             ok
);

   crc_state_e       state_q;
   logic [LEN_W-1:0] cnt_q;
   logic             mis_q;
   logic             bit_bad;
   logic             last_bit;

   assign bit_bad  = bit_in ^ msb;
   assign last_bit = (cnt_q == LEN_W'(1));
   assign out_vld  = (state_q == ST_TX);

   always_comb begin
      op = OP_HOLD;
      if (sof) begin
         op = OP_LOAD;
      end else begin
         unique case (state_q)
            ST_DATA:      op = bit_vld ? OP_DATA  : OP_HOLD;
            ST_TX, ST_RX: op = bit_vld ? OP_SHIFT : OP_HOLD;
            default:      op = OP_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         mis_q   <= 1'b0;
         done    <= 1'b0;
         ok      <= 1'b0;
      end else begin
         done <= 1'b0;
         ok   <= 1'b0;
         if (sof) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
            mis_q   <= 1'b0;
         end else begin
            unique case (state_q)
               ST_DATA: begin
                  if (eod) begin
                     if (len == '0) begin
                        state_q <= ST_IDLE;
                        done    <= chk_mode;
                        ok      <= chk_mode;
                     end else begin
                        state_q <= chk_mode ? ST_RX : ST_TX;
                        cnt_q   <= len;
                        mis_q   <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (bit_vld) begin
                     cnt_q <= cnt_q - LEN_W'(1);
                     if (last_bit) state_q <= ST_IDLE;
                  end
               end
               ST_RX: begin
                  if (bit_vld) begin
                     cnt_q <= cnt_q - LEN_W'(1);
                     mis_q <= mis_q | bit_bad;
                     if (last_bit) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                        ok      <= ~(mis_q | bit_bad);
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/crc_engine.sv
// Programmable-length serial CRC generator and checker.
module crc_engine
   import crc_pkg::*;
#(
   parameter int MAX_W = 8,
   parameter int LEN_W = $clog2(MAX_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_chk,
   input  logic [MAX_W-1:0] cfg_poly,
   input  logic [MAX_W-1:0] cfg_seed,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             sof,
   input  logic             eod,
   input  logic             bit_vld,
   input  logic             bit_in,
   output logic             crc_out,
   output logic             crc_out_vld,
   output logic             chk_done,
   output logic             chk_ok
);

   if (MAX_W < 1 || MAX_W > 32) begin : g_bad_width
      $error("crc_engine: MAX_W must lie in 1..32");
   end
   if (LEN_W < $clog2(MAX_W + 1)) begin : g_bad_len_w
      $error("crc_engine: LEN_W too narrow for MAX_W");
   end

   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_W);

   logic [MAX_W-1:0] poly_q;
   logic [LEN_W-1:0] len_q;
   logic             chk_q;
   logic [LEN_W-1:0] len_clamped;
   logic [MAX_W-1:0] mask;
   logic [MAX_W-1:0] top;
   logic [MAX_W-1:0] taps;
   logic             msb;
   logic             out_vld;
   crc_op_e          op;

   assign len_clamped = (cfg_len > LEN_MAX) ? LEN_MAX : cfg_len;
   assign taps        = poly_q & mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poly_q <= '0;
         len_q  <= '0;
         chk_q  <= 1'b0;
      end else if (sof) begin
         poly_q <= cfg_poly;
         len_q  <= len_clamped;
         chk_q  <= mode_chk;
      end
   end

   crc_len_decode #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_dec (
      .len  (len_q),
      .mask (mask),
      .top  (top)
   );

   crc_shift_reg #(.MAX_W(MAX_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .seed  (cfg_seed),
      .taps  (taps),
      .mask  (mask),
      .top   (top),
      .din   (bit_in),
      .msb   (msb)
   );

   crc_ctrl #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sof      (sof),
      .eod      (eod),
      .bit_vld  (bit_vld),
      .bit_in   (bit_in),
      .msb      (msb),
      .chk_mode (chk_q),
      .len      (len_q),
      .op       (op),
      .out_vld  (out_vld),
      .done     (chk_done),
      .ok       (chk_ok)
   );

   assign crc_out_vld = out_vld;
   assign crc_out     = out_vld & msb;

endmodule

// File: rtl/crc_engine_chk.sv
// Protocol checker attached to every crc_engine instance.
module crc_engine_chk #(
   parameter int MAX_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic sof,
   input logic eod,
   input logic bit_vld,
   input logic crc_out,
   input logic crc_out_vld,
   input logic chk_done,
   input logic chk_ok
);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      chk_done |=> !chk_done); // R6

   AST_OK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      chk_ok |-> chk_done); // R6

   AST_NO_DONE_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
      crc_out_vld |-> !chk_done); // R4

   AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_out_vld && !bit_vld && !sof && !eod) |=> (crc_out_vld && $stable(crc_out))); // R4

   AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> (!crc_out_vld && !chk_done)); // R9

   AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !crc_out_vld |-> !crc_out); // R1

endmodule

bind crc_engine crc_engine_chk #(.MAX_W(MAX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sof         (sof),
   .eod         (eod),
   .bit_vld     (bit_vld),
   .crc_out     (crc_out),
   .crc_out_vld (crc_out_vld),
   .chk_done    (chk_done),
   .chk_ok      (chk_ok)
);

// File: tb/crc_engine_test.sv
`timescale 1ns/1ps
module crc_engine_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_chk = 1'b0;
   logic [7:0] cfg_poly = 8'h11;
   logic [7:0] cfg_seed = 8'h0A;
   logic [3:0] cfg_len = 4'd4;
   logic       sof = 1'b0;
   logic       eod = 1'b0;
   logic       bit_vld = 1'b0;
   logic       bit_in = 1'b0;
   logic       crc_out;
   logic       crc_out_vld;
   logic       chk_done;
   logic       chk_ok;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   crc_engine uut (
      .clk(clk), .rst_n(rst_n), .mode_chk(mode_chk), .cfg_poly(cfg_poly),
      .cfg_seed(cfg_seed), .cfg_len(cfg_len), .sof(sof), .eod(eod),
      .bit_vld(bit_vld), .bit_in(bit_in), .crc_out(crc_out),
      .crc_out_vld(crc_out_vld), .chk_done(chk_done), .chk_ok(chk_ok)
   );

   // {poly, seed, len, message}
   localparam logic [35:0] VEC [0:6] = '{
      36'h11_0A_4_A5C3,
      36'h07_FF_8_1234,
      36'h03_00_3_FFFF,
      36'h01_01_1_C001,
      36'h1D_55_6_0F0F,
      36'h00_0A_0_BEEF,
      36'h2F_C3_7_8001
   };

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !finished) begin
         errors = errors + 1;
         $display("FAIL R4 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Bit-level reference of R3 with the clamp of R8
   function automatic logic [7:0] model_crc(logic [7:0] poly, logic [7:0] seed,
                                            logic [3:0] len, logic [15:0] msg);
      int         l;
      logic [7:0] m;
      logic [7:0] r;
      logic       fb;
      l = (len > 4'd8) ? 8 : int'(len);
      m = 8'((9'd1 << l) - 9'd1);
      r = seed & m;
      for (int i = 15; i >= 0; i--) begin
         fb = (l == 0) ? 1'b0 : (r[l-1] ^ msg[i]);
         r  = (r << 1) & m;
         if (fb) r = r ^ (poly & m);
      end
      return r;
   endfunction

   task automatic start_frame(logic [7:0] poly, logic [7:0] seed, logic [3:0] len,
                              logic chk, logic [15:0] msg, bit noisy);
      cfg_poly = poly; cfg_seed = seed; cfg_len = len; mode_chk = chk;
      sof = 1'b1; tick(); sof = 1'b0;
      if (noisy) begin // R2: scramble configuration after capture
         cfg_poly = ~poly; cfg_seed = ~seed; cfg_len = len + 4'd3; mode_chk = ~chk;
      end
      for (int i = 15; i >= 0; i--) begin
         bit_in = msg[i]; bit_vld = 1'b1; tick(); bit_vld = 1'b0;
         if (noisy) begin // R10: unqualified bits
            bit_in = ~msg[i]; tick();
         end
      end
      eod = 1'b1; tick(); eod = 1'b0;
   endtask

   task automatic run_gen(logic [7:0] poly, logic [7:0] seed, logic [3:0] len,
                          logic [15:0] msg, bit noisy, string tag);
      logic [7:0] got;
      int         n;
      int         l;
      l = (len > 4'd8) ? 8 : int'(len);
      got = '0; n = 0;
      start_frame(poly, seed, len, 1'b0, msg, noisy);
      for (int i = 0; i < l; i++) begin
         if (crc_out_vld) n++;
         got = {got[6:0], crc_out};
         bit_in = ~bit_in; bit_vld = 1'b1; tick(); bit_vld = 1'b0;
      end
      check({tag, " crc value"}, got, model_crc(poly, seed, len, msg));
      check({tag, " valid count"}, n, l);
      check({tag, " valid ends"}, crc_out_vld, 0);
   endtask

   task automatic run_chk(logic [7:0] poly, logic [7:0] seed, logic [3:0] len,
                          logic [15:0] msg, logic [7:0] rx, int exp_ok, bit noisy,
                          string tag);
      int l;
      l = (len > 4'd8) ? 8 : int'(len);
      start_frame(poly, seed, len, 1'b1, msg, noisy);
      for (int i = l - 1; i >= 0; i--) begin
         check({tag, " no early done"}, chk_done, 0);
         bit_in = rx[i]; bit_vld = 1'b1; tick(); bit_vld = 1'b0;
      end
      check({tag, " done"}, chk_done, 1);
      check({tag, " ok"}, chk_ok, exp_ok);
      tick();
      check({tag, " done pulse ends"}, chk_done, 0);
   endtask

   initial begin
      logic [7:0]  exp;
      logic [19:0] cw;
      logic [19:0] err;

      repeat (3) tick();
      check("R1 crc_out_vld at reset", crc_out_vld, 0);
      check("R1 crc_out at reset", crc_out, 0);
      check("R1 chk_done at reset", chk_done, 0);
      check("R1 chk_ok at reset", chk_ok, 0);
      rst_n = 1'b1;
      tick();
      check("R1 idle after release", crc_out_vld | chk_done, 0);

      // Table walk: generate, good check, corrupted check (R3 R4 R6)
      for (int k = 0; k < 7; k++) begin
         logic [7:0]  p;
         logic [7:0]  s;
         logic [3:0]  l;
         logic [15:0] m;
         {p, s, l, m} = VEC[k];
         exp = model_crc(p, s, l, m);
         run_gen(p, s, l, m, 1'b0, "R3 R4 table gen");
         run_chk(p, s, l, m, exp, 1, 1'b0, "R6 table good");
         if (l == 4'd0)
            run_chk(p, s, l, m, exp ^ 8'h01, 1, 1'b0, "R5 table len0");
         else
            run_chk(p, s, l, m, exp ^ 8'h01, 0, 1'b0, "R6 table bad");
      end

      // R5: length zero emits nothing, check passes on any message
      run_gen(8'hFF, 8'hFF, 4'd0, 16'h1357, 1'b0, "R5 len0 gen");
      run_chk(8'hFF, 8'hFF, 4'd0, 16'h2468, 8'h00, 1, 1'b0, "R5 len0 chk");

      // R2 and R10: configuration changes and unqualified bits are ignored
      run_gen(8'h11, 8'h0A, 4'd4, 16'h5A3C, 1'b1, "R2 R10 gen noisy");
      run_chk(8'h11, 8'h0A, 4'd4, 16'h5A3C, model_crc(8'h11, 8'h0A, 4'd4, 16'h5A3C),
              1, 1'b1, "R2 R10 chk noisy");

      // R8: lengths above 8 behave as 8
      run_gen(8'h9B, 8'h3C, 4'd12, 16'hC0DE, 1'b0, "R8 len12 gen");
      run_chk(8'h9B, 8'h3C, 4'd15, 16'hC0DE, model_crc(8'h9B, 8'h3C, 4'd8, 16'hC0DE),
              1, 1'b0, "R8 len15 chk");

      // R9: restart in data phase and while emitting CRC
      cfg_poly = 8'h07; cfg_seed = 8'h00; cfg_len = 4'd8; mode_chk = 1'b0;
      sof = 1'b1; tick(); sof = 1'b0;
      for (int i = 0; i < 5; i++) begin
         bit_in = 1'b1; bit_vld = 1'b1; tick(); bit_vld = 1'b0;
      end
      run_gen(8'h11, 8'h0A, 4'd4, 16'h0001, 1'b0, "R9 restart in data");
      start_frame(8'h07, 8'h00, 4'd8, 1'b0, 16'hFFFF, 1'b0);
      bit_vld = 1'b1; tick(); bit_vld = 1'b0;
      run_gen(8'h1D, 8'hA5, 4'd5, 16'h7E81, 1'b0, "R9 restart in tx");
      start_frame(8'h07, 8'h00, 4'd8, 1'b1, 16'h4242, 1'b0);
      bit_in = 1'b0; bit_vld = 1'b1; tick(); bit_vld = 1'b0;
      sof = 1'b1; tick(); sof = 1'b0;
      check("R9 abort in rx gives no done", chk_done, 0);

      // R7: every burst of 1..4 bits over the default codeword is caught
      exp = model_crc(8'h11, 8'h0A, 4'd4, 16'hA5C3);
      for (int b = 1; b <= 4; b++) begin
         int nmid;
         nmid = (b > 2) ? (1 << (b - 2)) : 1;
         for (int pos = 0; pos <= 20 - b; pos++) begin
            for (int mid = 0; mid < nmid; mid++) begin
               logic [19:0] pat;
               if (b == 1) pat = 20'd1;
               else        pat = 20'((1 << (b - 1)) | 1 | (mid << 1));
               err = pat << pos;
               cw  = {16'hA5C3, exp[3:0]} ^ err;
               run_chk(8'h11, 8'h0A, 4'd4, cw[19:4], {4'h0, cw[3:0]}, 0, 1'b0,
                       "R7 burst");
            end
         end
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule